// File: doc/BRIEF.md
# Checksummed Settings Store

This block keeps a 32-byte register file: ten bytes of node settings, twenty-one free user bytes and one check byte. The check byte always holds the XOR of every other byte. A host reaches the array through a byte port with a 5-bit address and 8-bit data. Each host write also updates the check byte, so software never has to maintain it.

When reset is released, a boot walker reads one byte per cycle and recomputes the XOR. If the result does not match the stored check byte, or if the restore strap was held during reset, it writes the factory defaults into the settings bytes and then seals a fresh check byte. The user bytes are never touched in either case. The array itself has no reset, so its contents survive a soft reset. The settings bytes are decoded continuously into named fields: node address, radio channel, transmit level, sleep length, reply timeout, serial rate code and its rate, pin-watch mask and feature bits.

Top module: `settings_store`

## Requirements
- R1: Addresses 0-9 are settings, 10-30 are user bytes and 31 is the check byte. A read accepted on one clock edge presents that byte on `acc_rdata` from that edge on. `acc_rdata` is 0 after reset.
- R2: A host write to address 0-30 stores the data and, on the same edge, sets byte 31 to the XOR of bytes 0-30.
- R3: A host write to address 31 changes nothing.
- R4: `busy` is high during reset. When the stored check byte matches and no restore was requested, `busy` falls 31 clock edges after reset release and no byte changes.
- R5: On a check mismatch, bytes 0-9 are reloaded with defaults, byte 31 is rewritten as the new XOR, and `busy` falls 42 edges after release. Bytes 10-30 keep their values.
- R6: When `restore_req` is high during reset, the default reload of R5 happens even when the check byte matches.
- R7: Default bytes 0..9 are 0x00, 0x02, 0x07, 0x0F, 0x00, 0x01, 0x02, 0x02, 0x80, 0x00.
- R8: While `busy` is high, `acc_ready` is low and host reads and writes are dropped: no byte and no `acc_rdata` value changes.
- R9: Decoded fields: `node_addr` = {byte0, byte1}; `rf_chan` = byte2[3:0]; `tx_level` = byte3[3:0]; `sleep_len` = {byte4, byte5}; `reply_tmo` = byte6; `baud_code` = byte7[2:0]; `watch_mask` = byte8; `feat_bits` = byte9.
- R10: `baud_rate` for codes 0..7 is 2400, 4800, 9600, 14400, 19200, 38400, 128000 and 250000. Bits 7:3 of byte 7 are ignored.
- R11: All 32 bytes keep their values across a soft reset when the check passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous soft reset |
| restore_req | input | 1 | Force default reload; sampled while in reset |
| acc_en | input | 1 | Host access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Byte address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, registered |
| acc_ready | output | 1 | Host accesses accepted |
| busy | output | 1 | Boot check or reload in progress |
| node_addr | output | 16 | Node address |
| rf_chan | output | 4 | Radio channel |
| tx_level | output | 4 | Transmit level |
| sleep_len | output | 16 | Sleep length in ticks |
| reply_tmo | output | 8 | Reply timeout |
| baud_code | output | 3 | Serial rate code |
| baud_rate | output | 18 | Serial rate in bit/s |
| watch_mask | output | 8 | Pin-watch mask |
| feat_bits | output | 8 | Feature bits |

## Verification
Host writes change a byte and the check byte on the accepting edge, and a read shows up on `acc_rdata` at that same edge. The bench therefore drives on a falling edge and samples at the next falling edge. The decoded outputs are combinational on the array, so they are sampled at the falling edge after the write. Boot length is measured by counting rising edges from a reset release made on a falling edge until `busy` is seen low, and that count must be exactly 31 or 42. The mismatch case is produced by cutting a forced reload short with reset after four default bytes have been written.

// File: rtl/setstore_pkg.sv
`timescale 1ns/1ps
package setstore_pkg;

   localparam int RATE_W = 18;

   typedef enum logic [1:0] {
      BT_SCAN,
      BT_LOAD,
      BT_SEAL,
      BT_IDLE
   } boot_state_e;

   function automatic logic [RATE_W-1:0] rate_of_code(input logic [2:0] code);
      logic [RATE_W-1:0] r;
      case (code)
         3'd0:    r = RATE_W'(2400);
         3'd1:    r = RATE_W'(4800);
         3'd2:    r = RATE_W'(9600);
         3'd3:    r = RATE_W'(14400);
         3'd4:    r = RATE_W'(19200);
         3'd5:    r = RATE_W'(38400);
         3'd6:    r = RATE_W'(128000);
         default: r = RATE_W'(250000);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/setstore_mem.sv
`timescale 1ns/1ps
module setstore_mem #(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wa_en_i,
   input  logic [AW-1:0]             wa_addr_i,
   input  logic [DW-1:0]             wa_data_i,
   input  logic                      ws_en_i,
   input  logic [DW-1:0]             ws_data_i,
   output logic [DEPTH-1:0][DW-1:0]  bytes_o
);

   // Cells carry no reset so that contents survive a soft reset.
   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [DW-1:0] q;
      if (g == DEPTH - 1) begin : g_sum
         always_ff @(posedge clk) begin
            if (ws_en_i) q <= ws_data_i;
         end
      end else begin : g_data
         always_ff @(posedge clk) begin
            if (wa_en_i && wa_addr_i == AW'(g)) q <= wa_data_i;
         end
      end
      assign bytes_o[g] = q;
   end

   // R3
   port_a_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wa_en_i |-> (wa_addr_i != AW'(DEPTH - 1)));

endmodule

// File: rtl/setstore_boot.sv
`timescale 1ns/1ps
module setstore_boot
   import setstore_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   parameter int SET_N = 10,
   localparam int AW     = $clog2(DEPTH),
   localparam int SET_AW = $clog2(SET_N)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      strap_i,
   input  logic [DEPTH-1:0][DW-1:0]  bytes_i,
   input  logic [SET_N-1:0][DW-1:0]  defaults_i,
   output logic                      busy_o,
   output logic                      wr_en_o,
   output logic [AW-1:0]             wr_addr_o,
   output logic [DW-1:0]             wr_data_o,
   output logic                      sum_en_o,
   output logic [DW-1:0]             sum_data_o
);

   localparam logic [AW-1:0] LAST_DATA = AW'(DEPTH - 2);
   localparam logic [AW-1:0] LAST_SET  = AW'(SET_N - 1);

   boot_state_e   state_q, state_d;
   logic [AW-1:0] idx_q, idx_d;
   logic [DW-1:0] acc_q, acc_d;
   logic          strap_q;
   logic [DW-1:0] cur_byte;
   logic [DW-1:0] def_byte;

   assign cur_byte = bytes_i[idx_q];
   assign def_byte = defaults_i[idx_q[SET_AW-1:0]];

   // The strap is captured on every clock while reset is held.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strap_q <= strap_i;
      else        strap_q <= strap_q;
   end

   always_comb begin
      state_d    = state_q;
      idx_d      = idx_q;
      acc_d      = acc_q;
      wr_en_o    = 1'b0;
      wr_addr_o  = idx_q;
      wr_data_o  = def_byte;
      sum_en_o   = 1'b0;
      sum_data_o = acc_q;
      case (state_q)
         BT_SCAN: begin
            acc_d = acc_q ^ cur_byte;
            if (idx_q == LAST_DATA) begin
               idx_d = '0;
               if (strap_q || (acc_d != bytes_i[DEPTH-1])) state_d = BT_LOAD;
               else                                        state_d = BT_IDLE;
            end else begin
               idx_d = idx_q + AW'(1);
            end
         end
         BT_LOAD: begin
            wr_en_o = 1'b1;
            acc_d   = acc_q ^ cur_byte ^ def_byte;
            if (idx_q == LAST_SET) begin
               idx_d   = '0;
               state_d = BT_SEAL;
            end else begin
               idx_d = idx_q + AW'(1);
            end
         end
         BT_SEAL: begin
            sum_en_o = 1'b1;
            state_d  = BT_IDLE;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BT_SCAN;
         idx_q   <= '0;
         acc_q   <= '0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         acc_q   <= acc_d;
      end
   end

   assign busy_o = (state_q != BT_IDLE);

   // R5
   reload_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (wr_addr_o < AW'(SET_N)));

   // R4
   idle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BT_IDLE) |=> (state_q == BT_IDLE));

   // R5
   seal_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sum_en_o |-> $past(wr_en_o));

endmodule

// File: rtl/setstore_decode.sv
`timescale 1ns/1ps
module setstore_decode
   import setstore_pkg::*;
#(
   parameter int DW     = 8,
   parameter int SET_N  = 10,
   parameter int CODE_W = 4
) (
   input  logic [SET_N-1:0][DW-1:0] set_i,
   output logic [2*DW-1:0]          node_addr_o,
   output logic [CODE_W-1:0]        chan_o,
   output logic [CODE_W-1:0]        level_o,
   output logic [2*DW-1:0]          sleep_o,
   output logic [DW-1:0]            tmo_o,
   output logic [2:0]               baud_code_o,
   output logic [RATE_W-1:0]        baud_rate_o,
   output logic [DW-1:0]            mask_o,
   output logic [DW-1:0]            feat_o
);

   // Byte positions of the decoded fields.
   localparam int B_NODE_HI = 0;
   localparam int B_NODE_LO = 1;
   localparam int B_CHAN    = 2;
   localparam int B_LEVEL   = 3;
   localparam int B_SLP_HI  = 4;
   localparam int B_SLP_LO  = 5;
   localparam int B_TMO     = 6;
   localparam int B_BAUD    = 7;
   localparam int B_MASK    = 8;
   localparam int B_FEAT    = 9;

   assign node_addr_o = {set_i[B_NODE_HI], set_i[B_NODE_LO]};
   assign sleep_o     = {set_i[B_SLP_HI], set_i[B_SLP_LO]};
   assign chan_o      = set_i[B_CHAN][CODE_W-1:0];
   assign level_o     = set_i[B_LEVEL][CODE_W-1:0];
   assign tmo_o       = set_i[B_TMO];
   assign baud_code_o = set_i[B_BAUD][2:0];
   assign baud_rate_o = rate_of_code(set_i[B_BAUD][2:0]);
   assign mask_o      = set_i[B_MASK];
   assign feat_o      = set_i[B_FEAT];

endmodule

// File: rtl/settings_store.sv
`timescale 1ns/1ps
module settings_store
   import setstore_pkg::*;
#(
   parameter int          DEPTH     = 32,
   parameter int          SET_N     = 10,
   parameter bit          READ_REG  = 1'b1,
   parameter logic [15:0] DEF_NODE  = 16'h0002,
   parameter logic [7:0]  DEF_CHAN  = 8'd7,
   parameter logic [7:0]  DEF_LEVEL = 8'd15,
   parameter logic [15:0] DEF_SLEEP = 16'h0001,
   parameter logic [7:0]  DEF_TMO   = 8'd2,
   parameter logic [7:0]  DEF_BAUD  = 8'd2,
   parameter logic [7:0]  DEF_MASK  = 8'h80,
   parameter logic [7:0]  DEF_FEAT  = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        restore_req,
   input  logic        acc_en,
   input  logic        acc_we,
   input  logic [4:0]  acc_addr,
   input  logic [7:0]  acc_wdata,
   output logic [7:0]  acc_rdata,
   output logic        acc_ready,
   output logic        busy,
   output logic [15:0] node_addr,
   output logic [3:0]  rf_chan,
   output logic [3:0]  tx_level,
   output logic [15:0] sleep_len,
   output logic [7:0]  reply_tmo,
   output logic [2:0]  baud_code,
   output logic [17:0] baud_rate,
   output logic [7:0]  watch_mask,
   output logic [7:0]  feat_bits
);

   localparam int DW = 8;
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW-1:0] SUM_ADDR = AW'(DEPTH - 1);

   if (DEPTH != 32) begin : g_bad_depth
      $error("settings_store: DEPTH must match the 5-bit address port");
   end
   if (SET_N != 10) begin : g_bad_setn
      $error("settings_store: the field decoder expects ten settings bytes");
   end
   if (RATE_W != 18) begin : g_bad_rate
      $error("settings_store: rate width must match the baud_rate port");
   end

   logic [DEPTH-1:0][DW-1:0] bytes;
   logic [SET_N-1:0][DW-1:0] defaults;

   assign defaults[0] = DEF_NODE[15:8];
   assign defaults[1] = DEF_NODE[7:0];
   assign defaults[2] = DEF_CHAN;
   assign defaults[3] = DEF_LEVEL;
   assign defaults[4] = DEF_SLEEP[15:8];
   assign defaults[5] = DEF_SLEEP[7:0];
   assign defaults[6] = DEF_TMO;
   assign defaults[7] = DEF_BAUD;
   assign defaults[8] = DEF_MASK;
   assign defaults[9] = DEF_FEAT;

   logic          boot_wr, boot_sum;
   logic [AW-1:0] boot_addr;
   logic [DW-1:0] boot_data, boot_sum_data;

   setstore_boot #(.DEPTH(DEPTH), .DW(DW), .SET_N(SET_N)) u_boot (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_i    (restore_req),
      .bytes_i    (bytes),
      .defaults_i (defaults),
      .busy_o     (busy),
      .wr_en_o    (boot_wr),
      .wr_addr_o  (boot_addr),
      .wr_data_o  (boot_data),
      .sum_en_o   (boot_sum),
      .sum_data_o (boot_sum_data)
   );

   logic host_wr, host_rd;
   assign acc_ready = ~busy;
   assign host_wr   = acc_en & acc_we & ~busy & (acc_addr != SUM_ADDR);
   assign host_rd   = acc_en & ~acc_we & ~busy;

   logic          wa_en, ws_en;
   logic [AW-1:0] wa_addr;
   logic [DW-1:0] wa_data, ws_data;

   always_comb begin
      wa_en   = boot_wr | host_wr;
      wa_addr = boot_wr ? boot_addr : acc_addr;
      wa_data = boot_wr ? boot_data : acc_wdata;
      ws_en   = boot_sum | host_wr;
      ws_data = boot_sum ? boot_sum_data
                         : (bytes[DEPTH-1] ^ bytes[acc_addr] ^ acc_wdata);
   end

   setstore_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .wa_en_i   (wa_en),
      .wa_addr_i (wa_addr),
      .wa_data_i (wa_data),
      .ws_en_i   (ws_en),
      .ws_data_i (ws_data),
      .bytes_o   (bytes)
   );

   if (READ_REG) begin : g_rd_reg
      logic [DW-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       rdata_q <= '0;
         else if (host_rd) rdata_q <= bytes[acc_addr];
      end
      assign acc_rdata = rdata_q;
   end else begin : g_rd_comb
      assign acc_rdata = bytes[acc_addr];
   end

   setstore_decode #(.DW(DW), .SET_N(SET_N), .CODE_W(4)) u_dec (
      .set_i       (bytes[SET_N-1:0]),
      .node_addr_o (node_addr),
      .chan_o      (rf_chan),
      .level_o     (tx_level),
      .sleep_o     (sleep_len),
      .tmo_o       (reply_tmo),
      .baud_code_o (baud_code),
      .baud_rate_o (baud_rate),
      .mask_o      (watch_mask),
      .feat_o      (feat_bits)
   );

   // Reference XOR for the checks below.
   logic [DW-1:0] sum_ref;
   always_comb begin
      sum_ref = '0;
      for (int i = 0; i < DEPTH - 1; i++) sum_ref ^= bytes[i];
   end

   // R2
   sum_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bytes[DEPTH-1] == sum_ref));

   // R3
   sum_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && acc_en && acc_we && acc_addr == SUM_ADDR) |=> $stable(bytes));

   // R8
   user_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(bytes[DEPTH-2:SET_N]));

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(acc_rdata));

   // R4
   busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !busy);

endmodule

// File: tb/tb_settings_store.sv
`timescale 1ns/1ps
module tb_settings_store;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        restore_req = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_we = 1'b0;
   logic [4:0]  acc_addr = '0;
   logic [7:0]  acc_wdata = '0;
   logic [7:0]  acc_rdata;
   logic        acc_ready, busy;
   logic [15:0] node_addr, sleep_len;
   logic [3:0]  rf_chan, tx_level;
   logic [7:0]  reply_tmo, watch_mask, feat_bits;
   logic [2:0]  baud_code;
   logic [17:0] baud_rate;

   always #4 clk = ~clk;

   settings_store dut (
      .clk(clk), .rst_n(rst_n), .restore_req(restore_req),
      .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_ready(acc_ready),
      .busy(busy), .node_addr(node_addr), .rf_chan(rf_chan),
      .tx_level(tx_level), .sleep_len(sleep_len), .reply_tmo(reply_tmo),
      .baud_code(baud_code), .baud_rate(baud_rate),
      .watch_mask(watch_mask), .feat_bits(feat_bits)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;
   logic [7:0] exp_mem [32];
   logic [7:0] defs [10] = '{8'h00, 8'h02, 8'h07, 8'h0F, 8'h00,
                             8'h01, 8'h02, 8'h02, 8'h80, 8'h00};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] xor_model();
      logic [7:0] s = '0;
      for (int i = 0; i < 31; i++) s ^= exp_mem[i];
      return s;
   endfunction

   function automatic logic [17:0] rate_model(input int c);
      int base [8] = '{2400, 4800, 9600, 14400, 19200, 38400, 128000, 250000};
      return 18'(base[c]);
   endfunction

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_we = 1'b0;
      if (a != 5'd31) begin
         exp_mem[a] = d;
         exp_mem[31] = xor_model();
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
      @(negedge clk);
      acc_en = 1'b0;
      d = acc_rdata;
   endtask

   task automatic hold_reset(input logic strap);
      @(negedge clk);
      rst_n = 1'b0; restore_req = strap;
      repeat (3) @(negedge clk);
   endtask

   // Release on a falling edge, count rising edges until busy is seen low.
   task automatic release_and_count(output int n);
      rst_n = 1'b1;
      n = 0;
      while (busy && n < 200) begin
         @(negedge clk);
         n++;
      end
      restore_req = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n;
      logic [7:0] d;

      // Reset state and forced reload (R6, R1, R4)
      hold_reset(1'b1);
      check("R4 busy during reset", busy, 1);
      check("R8 ready during reset", acc_ready, 0);
      check("R1 rdata after reset", acc_rdata, 0);
      release_and_count(n);
      check("R6 strap forces reload length", n, 42);
      for (int i = 0; i < 10; i++) begin
         rd(5'(i), d);
         check("R7 default byte", d, defs[i]);
      end
      check("R9 node default", node_addr, 16'h0002);
      check("R9 chan default", rf_chan, 7);
      check("R9 level default", tx_level, 15);
      check("R9 sleep default", sleep_len, 16'h0001);
      check("R10 default rate", baud_rate, 9600);

      // Fill everything so the model is complete
      for (int a = 0; a < 31; a++) wr(5'(a), 8'(a * 29 + 3));
      // R1/R2 sweep over every data address
      for (int a = 0; a < 31; a++) begin
         wr(5'(a), 8'(a * 37 + 5) ^ 8'h5A);
         rd(5'(a), d);
         check("R1 read back", d, exp_mem[a]);
         rd(5'd31, d);
         check("R2 check byte", d, xor_model());
      end

      // R3 write to the check byte
      wr(5'd31, ~exp_mem[31]);
      rd(5'd31, d);
      check("R3 check byte unchanged", d, exp_mem[31]);

      // R4/R11 clean soft reset keeps everything
      hold_reset(1'b0);
      release_and_count(n);
      check("R4 clean boot length", n, 31);
      for (int a = 0; a < 32; a++) begin
         rd(5'(a), d);
         check("R11 persisted byte", d, exp_mem[a]);
      end

      // R9/R10 decode
      wr(5'd0, 8'hAB); wr(5'd1, 8'hCD);
      check("R9 node_addr", node_addr, 16'hABCD);
      wr(5'd2, 8'hF9);
      check("R9 rf_chan", rf_chan, 9);
      wr(5'd3, 8'h3C);
      check("R9 tx_level", tx_level, 12);
      wr(5'd4, 8'h43); wr(5'd5, 8'h80);
      check("R9 sleep_len", sleep_len, 16'h4380);
      wr(5'd6, 8'h77);
      check("R9 reply_tmo", reply_tmo, 8'h77);
      wr(5'd8, 8'h5F);
      check("R9 watch_mask", watch_mask, 8'h5F);
      wr(5'd9, 8'hE0);
      check("R9 feat_bits", feat_bits, 8'hE0);
      for (int c = 0; c < 8; c++) begin
         wr(5'd7, 8'(c));
         check("R10 baud_rate", baud_rate, rate_model(c));
         check("R9 baud_code", baud_code, c);
         wr(5'd7, 8'(c) | 8'hF8);
         check("R10 upper bits ignored", baud_rate, rate_model(c));
      end

      // R8 accesses during boot are dropped
      rd(5'd12, d);
      hold_reset(1'b0);
      rst_n = 1'b1;
      check("R8 ready low while busy", acc_ready, 0);
      acc_en = 1'b1; acc_we = 1'b1; acc_addr = 5'd12; acc_wdata = ~exp_mem[12];
      @(negedge clk);
      acc_we = 1'b0; acc_addr = 5'd20;
      @(negedge clk);
      acc_en = 1'b0;
      n = 2;
      while (busy && n < 200) begin
         @(negedge clk);
         n++;
      end
      check("R4 boot length with stalled host", n, 31);
      check("R8 rdata unchanged", acc_rdata, 0);
      rd(5'd12, d);
      check("R8 write dropped", d, exp_mem[12]);

      // R5 mismatch: custom settings, then cut a forced reload short
      for (int i = 0; i < 10; i++) begin
         logic [7:0] delta;
         delta = (i < 8) ? 8'(1 << i) : ((i == 8) ? 8'h03 : 8'h05);
         wr(5'(i), defs[i] ^ delta);
      end
      hold_reset(1'b1);
      rst_n = 1'b1;
      repeat (35) @(posedge clk);
      #1 rst_n = 1'b0;
      restore_req = 1'b0;
      repeat (3) @(negedge clk);
      release_and_count(n);
      check("R5 mismatch reload length", n, 42);
      for (int i = 0; i < 10; i++) exp_mem[i] = defs[i];
      exp_mem[31] = xor_model();
      for (int a = 0; a < 32; a++) begin
         rd(5'(a), d);
         check((a >= 10 && a < 31) ? "R5 user byte kept" : "R5 reloaded byte", d, exp_mem[a]);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule